// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a 32-bit virtual address space with 4 KB pages. A requester presents a virtual address with an access kind (read or write, user or supervisor). In the same cycle the block reports a hit with the physical address, a miss, or a protection fault. The cache is organised as 16 sets of 4 ways. The page number splits into a set index (its low 4 bits) and a 16-bit tag (its upper bits).

On a miss, an external page walker resolves the translation and installs it through the fill port. Each entry carries four attributes: survives-context-switch, privileged-only, writable and already-dirty. A write that hits an entry whose already-dirty flag is clear is reported as a miss. This lets the walker mark the page dirty in memory once. A context flush drops every entry except those marked to survive it. A full flush drops everything.

Top module: `xlat_buf_top`

## Requirements
- R1: When `lk_req` is high and the indexed set holds a valid entry with a matching tag, an allowed access asserts `lk_hit`, and `lk_pa` equals the stored 20-bit frame number concatenated with `lk_va[11:0]`. The set index is `lk_va[15:12]` and the tag is `lk_va[31:16]`.
- R2: When no valid entry matches, `lk_miss` is asserted with `lk_hit` and `lk_fault` low. After reset every lookup misses.
- R3: A user access (`lk_user`=1) that matches a privileged-only entry asserts `lk_fault`, not `lk_hit`.
- R4: A write (`lk_write`=1) that matches a non-writable entry asserts `lk_fault`. A fault takes priority over the dirty rule of R5.
- R5: A permitted write that matches an entry whose already-dirty flag is clear asserts `lk_miss`, not `lk_hit`. Reads of that entry still hit.
- R6: A fill takes effect at the next rising clock edge. It uses the lowest-numbered invalid way of set `fl_vpn[3:0]`. If the set is full, it uses that set's round-robin pointer. The pointer starts at way 0 and advances by one (wrapping) only when it picks the victim.
- R7: A fill whose tag already sits valid in its set rewrites that way. No duplicate is created, and the round-robin pointer does not move.
- R8: `flush_ctx` invalidates every entry whose survive flag is clear. Entries with the flag set keep translating.
- R9: `flush_all` invalidates every entry, including entries with the survive flag set.
- R10: A fill presented in the same cycle as a flush is written after the flush and remains valid.
- R11: When `lk_req` is low, or when the result is not a hit, `lk_hit`, `lk_miss`, `lk_fault` and `lk_pa` follow a fixed rule. With `lk_req` low all three flags are low. `lk_pa` is zero whenever `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request valid |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation found and allowed |
| lk_miss | output | 1 | No usable entry; walker must fill |
| lk_fault | output | 1 | Protection violation on a matching entry |
| lk_pa | output | 32 | Physical address on hit, else zero |
| fl_en | input | 1 | Install an entry at the next edge |
| fl_vpn | input | 20 | Virtual page number of the new entry |
| fl_ppn | input | 20 | Physical frame number of the new entry |
| fl_keep | input | 1 | Entry survives context flush |
| fl_priv | input | 1 | Entry is privileged-only |
| fl_wr_ok | input | 1 | Entry allows writes |
| fl_dirty | input | 1 | Page already marked dirty |
| flush_ctx | input | 1 | Invalidate all non-surviving entries |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench targets the point where a full set must evict. A design that skipped invalid ways, or that moved its pointer on every fill, would evict the wrong tag, and a later hit or miss would give it away. It refills an existing tag with a new frame number. A design that duplicated the tag would return the stale frame, or would later lose both copies in the wrong order. It also writes to a clean but writable page, which a careless design would let hit. It checks that a privilege fault outranks the dirty miss. Finally, it runs both flush kinds against surviving entries and against a fill in the same cycle, which catches inverted survive masking and a flush that overrides a concurrent fill.

// File: rtl/xlat_buf_pkg.sv
// Shared constants and types for the translation buffer.
// Assumes 32-bit virtual addresses and 4 KB pages unless overridden at the top.
package xlat_buf_pkg;
    localparam int VA_BITS_D   = 32;
    localparam int PAGE_BITS_D = 12;
    localparam int SET_BITS_D  = 4;
    localparam int WAYS_D      = 4;
    localparam int PPN_BITS_D  = 20;

    // Per-entry attribute bits kept beside each translation.
    typedef struct packed {
        logic keep;    // survives context flush
        logic priv;    // privileged-only
        logic wr_ok;   // writable
        logic dirty;   // dirty already recorded in memory
    } xb_attr_t;

    // Lookup verdict, one-hot encoded for easy checking.
    typedef enum logic [2:0] {
        XB_IDLE  = 3'b000,
        XB_HIT   = 3'b001,
        XB_MISS  = 3'b010,
        XB_FAULT = 3'b100
    } xb_verdict_e;
endpackage

// File: rtl/xb_way_cmp.sv
// Compares one key tag against every way of a set row.
// Assumes the row never holds the same valid tag twice (the fill path
// rewrites an existing way), so at most one way matches.
module xb_way_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WAYS-1:0]              row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   row_tag,
    input  logic [TAG_W-1:0]             key_tag,
    output logic [WAYS-1:0]              match,
    output logic                         any_match,
    output logic [WAY_W-1:0]             match_idx
);
    // Per-way equality against the key.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = row_valid[w] && (row_tag[w] == key_tag);
    end

    // Encode the matching way into an index.
    always_comb begin
        any_match = 1'b0;
        match_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                any_match = 1'b1;
                match_idx = WAY_W'(w);
            end
        end
    end

    // R7: no duplicate tags may ever exist in a set.
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/xb_victim_pick.sv
// Chooses the way a fill writes into.
// Order: the way that already holds the tag, then the lowest invalid way,
// then the set's round-robin pointer. Reports whether the pointer was used.
module xb_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  row_valid,
    input  logic             tag_present,
    input  logic [WAY_W-1:0] tag_way,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] pick_way,
    output logic             pick_by_rr
);
    logic             have_free;
    logic [WAY_W-1:0] free_way;

    // Find the lowest-numbered invalid way.
    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!row_valid[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
    end

    // Apply the priority order for the destination way.
    always_comb begin
        pick_by_rr = 1'b0;
        if (tag_present) begin
            pick_way = tag_way;
        end else if (have_free) begin
            pick_way = free_way;
        end else begin
            pick_way   = rr_ptr;
            pick_by_rr = 1'b1;
        end
    end
endmodule

// File: rtl/xb_perm_chk.sv
// Turns a tag match plus entry attributes into a hit / miss / fault verdict.
// Privilege and write-protection faults outrank the dirty-not-recorded miss.
module xb_perm_chk
    import xlat_buf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        is_write,
    input  logic        is_user,
    input  logic        matched,
    input  xb_attr_t    attr,
    output xb_verdict_e verdict
);
    logic priv_bad;
    logic wr_bad;
    logic clean_wr;

    // Classify the access against the matched entry.
    always_comb begin
        priv_bad = is_user && attr.priv;
        wr_bad   = is_write && !attr.wr_ok;
        clean_wr = is_write && !attr.dirty;
        if (!req)                      verdict = XB_IDLE;
        else if (!matched)             verdict = XB_MISS;
        else if (priv_bad || wr_bad)   verdict = XB_FAULT;
        else if (clean_wr)             verdict = XB_MISS;
        else                           verdict = XB_HIT;
    end

    // R11: exactly one outcome while requested, none when idle.
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $countones(verdict) == 1);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> verdict == XB_IDLE);
    // R5: a write never hits a clean entry.
    p_clean_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && matched && is_write && !attr.dirty) |-> verdict != XB_HIT);
endmodule

// File: rtl/xlat_buf_top.sv
// Set-associative translation buffer: combinational lookup, edge-triggered
// fill, per-set round-robin replacement, context and full flushes.
// Assumes the page walker only fills after a reported miss or fault and
// holds fill inputs stable for the cycle fl_en is high.
module xlat_buf_top
    import xlat_buf_pkg::*;
#(
    parameter int VA_BITS   = VA_BITS_D,
    parameter int PAGE_BITS = PAGE_BITS_D,
    parameter int SET_BITS  = SET_BITS_D,
    parameter int WAYS      = WAYS_D,
    parameter int PPN_BITS  = PPN_BITS_D,
    localparam int VPN_W = VA_BITS - PAGE_BITS,
    localparam int TAG_W = VPN_W - SET_BITS,
    localparam int SETS  = 1 << SET_BITS,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int PA_W  = PPN_BITS + PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [VA_BITS-1:0] lk_va,
    input  logic               lk_write,
    input  logic               lk_user,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault,
    output logic [PA_W-1:0]    lk_pa,
    input  logic               fl_en,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic [PPN_BITS-1:0] fl_ppn,
    input  logic               fl_keep,
    input  logic               fl_priv,
    input  logic               fl_wr_ok,
    input  logic               fl_dirty,
    input  logic               flush_ctx,
    input  logic               flush_all
);
    // Storage.
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0]             keep_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [PPN_BITS-1:0]                   ppn_q  [SETS][WAYS];
    xb_attr_t                              attr_q [SETS][WAYS];
    logic [SETS-1:0][WAY_W-1:0]            rr_q;

    // Lookup address fields.
    logic [PAGE_BITS-1:0] lk_off;
    logic [SET_BITS-1:0]  lk_set;
    logic [TAG_W-1:0]     lk_tag;
    assign lk_off = lk_va[PAGE_BITS-1:0];
    assign lk_set = lk_va[PAGE_BITS +: SET_BITS];
    assign lk_tag = lk_va[VA_BITS-1 -: TAG_W];

    // Fill address fields.
    logic [SET_BITS-1:0] fl_set;
    logic [TAG_W-1:0]    fl_tag;
    assign fl_set = fl_vpn[SET_BITS-1:0];
    assign fl_tag = fl_vpn[VPN_W-1 -: TAG_W];

    // Lookup tag compare on the indexed set.
    logic [WAYS-1:0]  lk_match;
    logic             lk_any;
    logic [WAY_W-1:0] lk_way;
    xb_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
        .clk(clk), .rst_n(rst_n),
        .row_valid(valid_q[lk_set]), .row_tag(tag_q[lk_set]), .key_tag(lk_tag),
        .match(lk_match), .any_match(lk_any), .match_idx(lk_way)
    );

    // Fill tag compare, to rewrite an existing way instead of duplicating.
    logic [WAYS-1:0]  fl_match;
    logic             fl_any;
    logic [WAY_W-1:0] fl_hit_way;
    xb_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_cmp (
        .clk(clk), .rst_n(rst_n),
        .row_valid(valid_q[fl_set]), .row_tag(tag_q[fl_set]), .key_tag(fl_tag),
        .match(fl_match), .any_match(fl_any), .match_idx(fl_hit_way)
    );

    // Destination way for the fill.
    logic [WAY_W-1:0] fl_way;
    logic             fl_by_rr;
    xb_victim_pick #(.WAYS(WAYS)) u_pick (
        .row_valid(valid_q[fl_set]), .tag_present(fl_any), .tag_way(fl_hit_way),
        .rr_ptr(rr_q[fl_set]), .pick_way(fl_way), .pick_by_rr(fl_by_rr)
    );

    // Permission and dirty checks on the matched entry.
    xb_attr_t    lk_attr;
    xb_verdict_e lk_verdict;
    assign lk_attr = attr_q[lk_set][lk_way];
    xb_perm_chk u_perm (
        .clk(clk), .rst_n(rst_n),
        .req(lk_req), .is_write(lk_write), .is_user(lk_user),
        .matched(lk_any), .attr(lk_attr), .verdict(lk_verdict)
    );

    // Drive lookup outputs; address is zero unless translating.
    always_comb begin
        lk_hit   = (lk_verdict == XB_HIT);
        lk_miss  = (lk_verdict == XB_MISS);
        lk_fault = (lk_verdict == XB_FAULT);
        lk_pa    = lk_hit ? {ppn_q[lk_set][lk_way], lk_off} : '0;
    end

    // Next pointer value after a round-robin eviction.
    logic [WAY_W-1:0] rr_next;
    assign rr_next = (rr_q[fl_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[fl_set] + 1'b1;

    // Valid bits and replacement pointers: flush first, then the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            if (flush_all)      valid_q <= '0;
            else if (flush_ctx) valid_q <= valid_q & keep_q;
            if (fl_en) begin
                valid_q[fl_set][fl_way] <= 1'b1;
                if (fl_by_rr) rr_q[fl_set] <= rr_next;
            end
        end
    end

    // Entry payload written on fill; not reset, qualified by valid.
    always_ff @(posedge clk) begin
        if (fl_en) begin
            tag_q[fl_set][fl_way]  <= fl_tag;
            keep_q[fl_set][fl_way] <= fl_keep;
            ppn_q[fl_set][fl_way]  <= fl_ppn;
            attr_q[fl_set][fl_way] <= '{keep: fl_keep, priv: fl_priv,
                                        wr_ok: fl_wr_ok, dirty: fl_dirty};
        end
    end

    // R9: full flush without a fill leaves nothing valid.
    p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fl_en) |=> valid_q == '0);
    // R8: context flush leaves only surviving entries.
    p_flush_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ctx && !fl_en) |=> (valid_q & ~keep_q) == '0);
    // R10: a fill is valid after the edge even with a flush.
    p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> valid_q[$past(fl_set)][$past(fl_way)]);
    // R6: replacement pointers move only on a fill.
    p_rr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en |=> $stable(rr_q));
    // R1: a hit keeps the page offset untouched.
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]);
endmodule

// File: tb/xlat_buf_top_tb_top.sv
module xlat_buf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req, lk_write, lk_user;
    logic [31:0] lk_va;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_pa;
    logic        fl_en, fl_keep, fl_priv, fl_wr_ok, fl_dirty;
    logic [19:0] fl_vpn, fl_ppn;
    logic        flush_ctx, flush_all;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    xlat_buf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_va(lk_va), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
        .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_keep(fl_keep),
        .fl_priv(fl_priv), .fl_wr_ok(fl_wr_ok), .fl_dirty(fl_dirty),
        .flush_ctx(flush_ctx), .flush_all(flush_all)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic        hit;
        logic        flt;
        logic        mis;
        logic [31:0] pa;
    } vec_t;

    // Lookups after three fills; the comment names the requirement.
    localparam vec_t VECS [10] = '{
        '{32'h12345ABC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hABCDEABC}, // R1 read
        '{32'h12345ABC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hABCDEABC}, // R1 write dirty
        '{32'h00013010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R3 user on priv
        '{32'h00013010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h11111010}, // R1 priv read
        '{32'h00013010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},        // R4 write RO
        '{32'h77775FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h22222FFF}, // R5 clean read
        '{32'h77775FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0},        // R5 clean write
        '{32'h00013010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R4 fault over dirty
        '{32'h12346000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},        // R2 other set
        '{32'h12355000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0}         // R2 other tag
    };

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual hit/miss/fault/pa=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Present a lookup after a falling edge and compare mid-phase.
    task automatic look(input string req, input logic [31:0] va, input logic wr,
                        input logic us, input logic h, input logic m,
                        input logic f, input logic [31:0] pa);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_write = wr; lk_user = us;
        #2;
        check(req, {lk_hit, lk_miss, lk_fault, lk_pa}, {h, m, f, pa});
        lk_req = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic k,
                        input logic p, input logic w, input logic d,
                        input logic fc, input logic fa);
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn;
        fl_keep = k; fl_priv = p; fl_wr_ok = w; fl_dirty = d;
        flush_ctx = fc; flush_all = fa;
        @(negedge clk);
        fl_en = 1'b0; flush_ctx = 1'b0; flush_all = 1'b0;
    endtask

    task automatic flush(input logic fc, input logic fa);
        @(negedge clk);
        flush_ctx = fc; flush_all = fa;
        @(negedge clk);
        flush_ctx = 1'b0; flush_all = 1'b0;
    endtask

    initial begin : watchdog
        #800000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; lk_write = 1'b0; lk_user = 1'b0;
        fl_en = 1'b0; fl_vpn = '0; fl_ppn = '0; fl_keep = 1'b0; fl_priv = 1'b0;
        fl_wr_ok = 1'b0; fl_dirty = 1'b0; flush_ctx = 1'b0; flush_all = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R11: empty after reset, idle when not requested.
        look("R2 reset empty", 32'h12345ABC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        @(negedge clk); lk_va = 32'h12345ABC; #2;
        check("R11 idle", {lk_hit, lk_miss, lk_fault, lk_pa}, 35'h0);

        fill(20'h12345, 20'hABCDE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        fill(20'h00013, 20'h11111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        fill(20'h77775, 20'h22222, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 10; i++) begin
            look($sformatf("vector %0d (R1-R5 table)", i), VECS[i].va, VECS[i].wr,
                 VECS[i].us, VECS[i].hit, VECS[i].mis, VECS[i].flt, VECS[i].pa);
        end

        // R7: refill same tag, now dirty with a new frame.
        fill(20'h77775, 20'h33333, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        look("R7 overwrite", 32'h77775004, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h33333004);

        // R6: set 9 fills A..D take free ways, E evicts way 0 (A), F evicts way 1 (B).
        for (int t = 0; t < 6; t++) begin
            fill({16'(16'hA000 + t), 4'h9}, 20'(20'h40000 + t), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        end
        look("R6 A evicted", 32'hA0009000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        look("R6 B evicted", 32'hA0019000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        look("R6 C kept",    32'hA0029000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h40002000);
        look("R6 E present", 32'hA0049000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h40004000);
        look("R6 F present", 32'hA0059000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h40005000);

        // R8: context flush keeps survivors only.
        flush(1'b1, 1'b0);
        look("R8 drop", 32'h12345000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        look("R8 keep", 32'h77775000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h33333000);

        // R10: fill together with context flush survives.
        fill(20'h55552, 20'h66666, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        look("R10 fill+flush", 32'h55552123, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h66666123);

        // R9: full flush drops survivors too.
        flush(1'b0, 1'b1);
        look("R9 keep gone", 32'h77775000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        look("R9 all gone",  32'h55552000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule